// File: doc/BRIEF.md
# I2C Target with Masked Address Match

This block is the target (slave) side of a two-wire I2C bus. It watches SCL and SDA through a synchronizer and finds START and STOP conditions. It then shifts in the 7-bit address that follows a START and acknowledges the address by itself whenever the address fits the programmed pattern. The pattern has two parts: a programmed address and a per-bit mask. Any mask bit that is zero makes that address bit a don't-care, so a single setting can answer a whole group of bus addresses.

When a write is addressed to the target, each received byte goes into a small receive FIFO, and the target acknowledges it as long as there is room. As an option, the address byte that matched can be placed in the FIFO ahead of the data bytes, so firmware can see which address in the group was used. When a read is addressed to the target, bytes are sent from a one-byte transmit register. If that register is empty when a byte is due, the target holds SCL low until firmware writes it. A second option makes every acknowledged address raise the interrupt flag and hold SCL low until firmware clears the flag.

Top module: `i2c_mask_target`

## Requirements
- R1: The address byte carries the address in bits 7:1 and the direction in bit 0 (1 = read). When `cfg_en` is 1 and `((addr ^ cfg_addr) & cfg_mask) == 0`, the target pulls SDA low (`sda_oe` = 1) during the ninth clock. A mask bit of 1 means that address bit is compared.
- R2: When the address does not match, or `cfg_en` is 0, the target leaves SDA released in the ninth clock. Until the next START it acknowledges nothing and stores nothing.
- R3: When `cfg_capture` is 1, the matched address byte, with its direction bit, is written into the receive FIFO before any data byte of that transfer.
- R4: When `cfg_force_hold` is 1, an acknowledged address sets `irq_flag` and holds SCL low (`scl_oe` = 1) until firmware pulses `irq_clear`. When it is 0, the address acknowledge alone neither sets the flag nor holds SCL.
- R5: In a write, each received data byte is acknowledged, stored in the FIFO in arrival order, and sets `irq_flag`. No clock hold is applied.
- R6: In a read, bytes are sent MSB first from the value last written with `tx_wr`. Whenever a byte is due and the transmit register is empty, `irq_flag` is set and SCL is held low until a byte is written. A controller NACK ends the read.
- R7: The receive FIFO holds 4 entries and drives `rx_empty` and `rx_full`. A data byte that arrives while the FIFO is full is NACKed and discarded.
- R8: A repeated START restarts the address phase, even when the earlier address was ignored.
- R9: After reset, `sda_oe`, `scl_oe` and `irq_flag` are 0, and `rx_empty` and `tx_empty` are 1.
- R10: If a received byte is written into the FIFO in the same cycle as an `rx_rd` pop, the byte is kept and only the oldest entry is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL level sensed on the bus |
| scl_oe | output | 1 | 1 holds SCL low (clock hold) |
| sda_i | input | 1 | SDA level sensed on the bus |
| sda_oe | output | 1 | 1 pulls SDA low |
| cfg_en | input | 1 | Enables address matching |
| cfg_addr | input | 7 | Programmed target address |
| cfg_mask | input | 7 | Per-bit compare mask, 1 = compared |
| cfg_capture | input | 1 | Store matched address byte in FIFO |
| cfg_force_hold | input | 1 | Flag and hold SCL after address acknowledge |
| irq_flag | output | 1 | Interrupt flag |
| irq_clear | input | 1 | One-cycle pulse that clears `irq_flag` |
| rx_rd | input | 1 | Pops one FIFO entry |
| rx_data | output | 8 | Oldest FIFO entry |
| rx_empty | output | 1 | FIFO is empty |
| rx_full | output | 1 | FIFO is full |
| tx_wr | input | 1 | Writes the transmit register |
| tx_data | input | 8 | Byte to transmit |
| tx_empty | output | 1 | Transmit register is empty |

## Verification
A FIFO write of a received byte and a firmware pop of the FIFO can land in the same clock cycle. To provoke this, the bench loads three bytes. It then asserts `rx_rd` in exactly the cycle in which the falling SCL edge after the eighth bit of a fourth byte takes effect, counting from when it drives SCL low. The outcome is judged by draining the FIFO: the second, third and fourth bytes must come out in that order and the FIFO must then be empty, which shows that the pop removed only the oldest entry and the new byte was kept.

// File: rtl/i2c_mask_tgt_pkg.sv
package i2c_mask_tgt_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 2);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WDAT,
    ST_RDAT,
    ST_SKIP
  } tgt_state_t;
endpackage

// File: rtl/i2c_mask_tgt_sync.sv
module i2c_mask_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_p  <= scl_sh[STAGES-1];
      sda_p  <= sda_sh[STAGES-1];
    end
  end

  assign scl_q     = scl_sh[STAGES-1];
  assign sda_q     = sda_sh[STAGES-1];
  assign scl_rise  = scl_q & ~scl_p;
  assign scl_fall  = ~scl_q & scl_p;
  assign start_det = scl_q & scl_p & sda_p & ~sda_q;
  assign stop_det  = scl_q & scl_p & ~sda_p & sda_q;
endmodule

// File: rtl/i2c_mask_tgt_match.sv
module i2c_mask_tgt_match
  import i2c_mask_tgt_pkg::*;
(
  input  logic              en,
  input  logic [ADDR_W-1:0] rx_addr,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [ADDR_W-1:0] care_mask,
  output logic              hit
);
  logic [ADDR_W-1:0] diff;

  always_comb begin
    diff = (rx_addr ^ own_addr) & care_mask;
    hit  = en && (diff == '0);
  end
endmodule

// File: rtl/i2c_mask_tgt_fifo.sv
module i2c_mask_tgt_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [OCC_W-1:0] occ;
  logic do_wr, do_rd;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (occ == OCC_W'(DEPTH));
  assign empty   = (occ == '0);
  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && !empty;
  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      occ <= '0;
    end else begin
      if (do_wr) wp <= ptr_next(wp);
      if (do_rd) rp <= ptr_next(rp);
      case ({do_wr, do_rd})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full); // R7
  AST_OCC_LIMIT: assert property (@(posedge clk) disable iff (rst)
    occ <= OCC_W'(DEPTH)); // R7
endmodule

// File: rtl/i2c_mask_target.sv
module i2c_mask_target
  import i2c_mask_tgt_pkg::*;
#(
  parameter int FIFO_DEPTH  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  output logic              scl_oe,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              cfg_en,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] cfg_mask,
  input  logic              cfg_capture,
  input  logic              cfg_force_hold,
  output logic              irq_flag,
  input  logic              irq_clear,
  input  logic              rx_rd,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_empty,
  output logic              rx_full,
  input  logic              tx_wr,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              tx_empty
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W + 1);

  logic scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;
  logic addr_hit, addr_ok, push, byte_done;
  tgt_state_t st;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh, tx_buf;
  logic tx_valid, rw_bit, m_ack, need_load, hold;

  i2c_mask_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_mask_tgt_match u_match (
    .en(cfg_en), .rx_addr(rx_sh[BYTE_W-1:1]), .own_addr(cfg_addr),
    .care_mask(cfg_mask), .hit(addr_hit)
  );

  assign byte_done = scl_fall && (bit_cnt == LAST_BIT);
  assign addr_ok   = addr_hit && (!cfg_capture || !rx_full);
  assign push      = byte_done &&
                     (((st == ST_ADDR) && addr_ok && cfg_capture) ||
                      ((st == ST_WDAT) && !rx_full));

  i2c_mask_tgt_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(BYTE_W)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(push), .wr_data(rx_sh),
    .rd_en(rx_rd), .rd_data(rx_data), .empty(rx_empty), .full(rx_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      tx_buf    <= '0;
      tx_valid  <= 1'b0;
      rw_bit    <= 1'b0;
      m_ack     <= 1'b0;
      need_load <= 1'b0;
      hold      <= 1'b0;
      sda_oe    <= 1'b0;
      irq_flag  <= 1'b0;
    end else begin
      if (irq_clear) irq_flag <= 1'b0;
      if (hold && !irq_flag && !need_load) hold <= 1'b0;

      if (start_det) begin
        st        <= ST_ADDR;
        bit_cnt   <= '0;
        sda_oe    <= 1'b0;
        hold      <= 1'b0;
        need_load <= 1'b0;
      end else if (stop_det) begin
        st        <= ST_IDLE;
        sda_oe    <= 1'b0;
        hold      <= 1'b0;
        need_load <= 1'b0;
      end else begin
        if (scl_rise && (st != ST_IDLE) && (st != ST_SKIP)) begin
          if (bit_cnt < LAST_BIT)  rx_sh   <= {rx_sh[BYTE_W-2:0], sda_q};
          if (bit_cnt == LAST_BIT) m_ack   <= !sda_q;
          if (bit_cnt < ACK_BIT)   bit_cnt <= bit_cnt + 1'b1;
        end

        if (scl_fall) begin
          case (st)
            ST_ADDR: begin
              if (bit_cnt == LAST_BIT) begin
                if (addr_ok) begin
                  sda_oe <= 1'b1;
                  rw_bit <= rx_sh[0];
                end else begin
                  st <= ST_SKIP;
                end
              end else if (bit_cnt == ACK_BIT) begin
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
                if (rw_bit) begin
                  st        <= ST_RDAT;
                  need_load <= 1'b1;
                end else begin
                  st <= ST_WDAT;
                end
                if (cfg_force_hold) begin
                  hold     <= 1'b1;
                  irq_flag <= 1'b1;
                end
              end
            end
            ST_WDAT: begin
              if (bit_cnt == LAST_BIT) begin
                if (!rx_full) begin
                  sda_oe   <= 1'b1;
                  irq_flag <= 1'b1;
                end
              end else if (bit_cnt == ACK_BIT) begin
                sda_oe  <= 1'b0;
                bit_cnt <= '0;
              end
            end
            ST_RDAT: begin
              if (bit_cnt == LAST_BIT) begin
                sda_oe <= 1'b0;
              end else if (bit_cnt == ACK_BIT) begin
                if (m_ack) begin
                  bit_cnt   <= '0;
                  need_load <= 1'b1;
                end else begin
                  st <= ST_SKIP;
                end
              end else if (bit_cnt != '0) begin
                sda_oe <= ~tx_sh[BYTE_W-1];
                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
              end
            end
            default: ;
          endcase
        end

        if ((st == ST_RDAT) && need_load) begin
          if (tx_valid) begin
            tx_sh     <= {tx_buf[BYTE_W-2:0], 1'b0};
            sda_oe    <= ~tx_buf[BYTE_W-1];
            tx_valid  <= 1'b0;
            need_load <= 1'b0;
          end else begin
            hold     <= 1'b1;
            irq_flag <= 1'b1;
          end
        end
      end

      if (tx_wr) begin
        tx_buf   <= tx_data;
        tx_valid <= 1'b1;
      end
    end
  end

  assign scl_oe   = hold;
  assign tx_empty = !tx_valid;

  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SKIP) |-> !sda_oe); // R2
  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (rst)
    ($fell(hold) && !$past(start_det) && !$past(stop_det)) |-> !$past(irq_flag)); // R4
  AST_SDA_STILL_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
    ($past(scl_q) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe)); // R6
  AST_PUSH_ROOM: assert property (@(posedge clk) disable iff (rst)
    (push && (st == ST_WDAT)) |=> sda_oe); // R5
endmodule

// File: tb/sim_i2c_mask_target.sv
`timescale 1ns/1ps
module sim_i2c_mask_target;
  localparam int Q = 10;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, m_scl, m_sda;
  logic scl_oe, sda_oe, scl_bus, sda_bus;
  logic cfg_en, cfg_capture, cfg_force_hold;
  logic [6:0] cfg_addr, cfg_mask;
  logic irq_flag, irq_clear, rx_rd, rx_empty, rx_full, tx_wr, tx_empty;
  logic [7:0] rx_data, tx_data;

  assign scl_bus = m_scl & ~scl_oe;
  assign sda_bus = m_sda & ~sda_oe;

  i2c_mask_target u0 (
    .clk(clk), .rst(rst), .scl_i(scl_bus), .scl_oe(scl_oe),
    .sda_i(sda_bus), .sda_oe(sda_oe), .cfg_en(cfg_en), .cfg_addr(cfg_addr),
    .cfg_mask(cfg_mask), .cfg_capture(cfg_capture), .cfg_force_hold(cfg_force_hold),
    .irq_flag(irq_flag), .irq_clear(irq_clear), .rx_rd(rx_rd), .rx_data(rx_data),
    .rx_empty(rx_empty), .rx_full(rx_full), .tx_wr(tx_wr), .tx_data(tx_data),
    .tx_empty(tx_empty)
  );

  int checks = 0, errors = 0;
  int flag_cnt = 0, stretch_cnt = 0;
  int tx_i = 0, tx_n = 0;
  bit done = 0;
  logic [7:0] tx_q [4];
  logic [7:0] exp_q [$];

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit f_hit(input logic [6:0] a, input logic [6:0] s, input logic [6:0] m);
    return ((a ^ s) & m) == 7'd0;
  endfunction

  always @(negedge clk) if (m_scl && !scl_bus) stretch_cnt++;

  initial begin
    forever begin
      @(negedge clk);
      if (!rst && irq_flag) begin
        flag_cnt++;
        repeat (30) @(negedge clk);
        if (tx_empty && tx_i < tx_n) begin
          tx_wr = 1'b1; tx_data = tx_q[tx_i]; tx_i++;
          @(negedge clk); tx_wr = 1'b0;
        end
        irq_clear = 1'b1;
        @(negedge clk); irq_clear = 1'b0;
      end
    end
  end

  task automatic wait_q(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl_high;
    while (!scl_bus) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; wait_q(Q);
    m_scl = 1'b1; wait_scl_high; wait_q(Q);
    m_sda = 1'b0; wait_q(Q);
    m_scl = 1'b0; wait_q(Q);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; wait_q(Q);
    m_scl = 1'b1; wait_scl_high; wait_q(Q);
    m_sda = 1'b1; wait_q(Q);
  endtask

  task automatic put_bit(input bit b, input bit pop_now);
    m_sda = b; wait_q(Q);
    m_scl = 1'b1; wait_scl_high; wait_q(Q);
    m_scl = 1'b0;
    if (pop_now) begin
      wait_q(2); rx_rd = 1'b1;
      wait_q(1); rx_rd = 1'b0;
      wait_q(Q - 3);
    end else begin
      wait_q(Q);
    end
  endtask

  task automatic get_bit(output bit b);
    m_sda = 1'b1; wait_q(Q);
    m_scl = 1'b1; wait_scl_high; wait_q(Q);
    b = sda_bus;
    m_scl = 1'b0; wait_q(Q);
  endtask

  task automatic put_byte(input logic [7:0] v, input bit pop_now, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) put_bit(v[i], pop_now && (i == 0));
    get_bit(b);
    ack = !b;
  endtask

  task automatic get_byte(input bit mack, output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b); v[i] = b;
    end
    put_bit(!mack, 1'b0);
  endtask

  task automatic drain(input string req);
    while (exp_q.size() > 0) begin
      @(negedge clk);
      check_eq(req, "rx_empty before pop", int'(rx_empty), 0);
      check_eq(req, "rx_data", int'(rx_data), int'(exp_q[0]));
      rx_rd = 1'b1;
      @(negedge clk); rx_rd = 1'b0;
      void'(exp_q.pop_front());
    end
    @(negedge clk);
    check_eq(req, "rx_empty after drain", int'(rx_empty), 1);
  endtask

  task automatic do_write(input logic [6:0] s, input logic [6:0] m, input logic [6:0] a,
                          input bit cap, input bit frc, input bit en, input int nb);
    bit ack, hit;
    logic [7:0] d;
    cfg_addr = s; cfg_mask = m; cfg_capture = cap; cfg_force_hold = frc; cfg_en = en;
    @(negedge clk);
    flag_cnt = 0; stretch_cnt = 0;
    hit = en && f_hit(a, s, m);
    bus_start;
    put_byte({a, 1'b0}, 1'b0, ack);
    check_eq(hit ? "R1" : "R2", "address ack", int'(ack), int'(hit));
    if (hit && cap) exp_q.push_back({a, 1'b0});
    for (int k = 0; k < nb; k++) begin
      d = 8'($urandom);
      put_byte(d, 1'b0, ack);
      check_eq(hit ? "R5" : "R2", "data ack", int'(ack), int'(hit));
      if (hit) exp_q.push_back(d);
    end
    bus_stop;
    wait_q(60);
    check_eq(frc ? "R4" : "R5", "flag count", flag_cnt, hit ? nb + int'(frc) : 0);
    check_eq("R4", "clock hold seen", int'(stretch_cnt > 0), int'(hit && frc));
    drain(!hit ? "R2" : (cap ? "R3" : "R5"));
  endtask

  initial begin
    bit ack;
    logic [7:0] v, b0, b1, b2, b3;
    logic [6:0] s, m, a;
    void'($urandom(32'd20240611));
    rst = 1'b1; m_scl = 1'b1; m_sda = 1'b1;
    cfg_en = 1'b1; cfg_addr = 7'h50; cfg_mask = 7'h7f; cfg_capture = 1'b0; cfg_force_hold = 1'b0;
    irq_clear = 1'b0; rx_rd = 1'b0; tx_wr = 1'b0; tx_data = 8'h00;
    wait_q(6);
    rst = 1'b0;
    wait_q(4);
    check_eq("R9", "sda_oe", int'(sda_oe), 0);
    check_eq("R9", "scl_oe", int'(scl_oe), 0);
    check_eq("R9", "irq_flag", int'(irq_flag), 0);
    check_eq("R9", "rx_empty", int'(rx_empty), 1);
    check_eq("R9", "tx_empty", int'(tx_empty), 1);

    do_write(7'h50, 7'h7f, 7'h50, 1'b0, 1'b1, 1'b1, 2);
    do_write(7'h50, 7'h7f, 7'h50, 1'b1, 1'b0, 1'b1, 2);
    do_write(7'h50, 7'h7c, 7'h53, 1'b1, 1'b0, 1'b1, 1);
    do_write(7'h50, 7'h7c, 7'h54, 1'b0, 1'b0, 1'b1, 1);
    do_write(7'h50, 7'h7f, 7'h50, 1'b0, 1'b0, 1'b0, 1);

    for (int t = 0; t < 10; t++) begin
      s = 7'($urandom);
      m = (t % 3 == 0) ? 7'h7f : 7'($urandom);
      a = ($urandom % 2 == 1) ? ((s & m) | (7'($urandom) & ~m)) : 7'($urandom);
      do_write(s, m, a, 1'($urandom % 2), 1'($urandom % 2), 1'b1, 1 + int'($urandom % 3));
    end

    // R6: read with empty transmit register, firmware supplies bytes
    cfg_addr = 7'h3a; cfg_mask = 7'h7f; cfg_capture = 1'b0; cfg_force_hold = 1'b0; cfg_en = 1'b1;
    tx_q[0] = 8'hc5; tx_q[1] = 8'h3c; tx_i = 0; tx_n = 2;
    @(negedge clk); flag_cnt = 0; stretch_cnt = 0;
    bus_start;
    put_byte({7'h3a, 1'b1}, 1'b0, ack);
    check_eq("R6", "read address ack", int'(ack), 1);
    get_byte(1'b1, v);
    check_eq("R6", "read byte 0", int'(v), 8'hc5);
    get_byte(1'b0, v);
    check_eq("R6", "read byte 1", int'(v), 8'h3c);
    bus_stop;
    wait_q(60);
    check_eq("R6", "tx flag count", flag_cnt, 2);
    check_eq("R6", "tx hold seen", int'(stretch_cnt > 0), 1);
    tx_n = 0;

    // R7: fifo full rejects the fifth byte
    cfg_addr = 7'h11;
    @(negedge clk);
    bus_start;
    put_byte({7'h11, 1'b0}, 1'b0, ack);
    check_eq("R7", "address ack", int'(ack), 1);
    for (int k = 0; k < 5; k++) begin
      v = 8'(8'h90 + k);
      put_byte(v, 1'b0, ack);
      check_eq("R7", "byte ack vs room", int'(ack), int'(k < 4));
      if (k < 4) exp_q.push_back(v);
    end
    bus_stop;
    wait_q(60);
    check_eq("R7", "rx_full", int'(rx_full), 1);
    drain("R7");

    // R8: ignored address, then repeated start with own address
    cfg_addr = 7'h21;
    @(negedge clk);
    bus_start;
    put_byte({7'h22, 1'b0}, 1'b0, ack);
    check_eq("R8", "foreign address nack", int'(ack), 0);
    put_byte(8'h5a, 1'b0, ack);
    check_eq("R8", "ignored byte nack", int'(ack), 0);
    bus_start;
    put_byte({7'h21, 1'b0}, 1'b0, ack);
    check_eq("R8", "address after repeated start", int'(ack), 1);
    put_byte(8'ha7, 1'b0, ack);
    check_eq("R8", "byte after repeated start", int'(ack), 1);
    exp_q.push_back(8'ha7);
    bus_stop;
    wait_q(60);
    drain("R8");

    // R10: fifo push and pop in the same cycle
    b0 = 8'h01; b1 = 8'h12; b2 = 8'h23; b3 = 8'h34;
    @(negedge clk);
    bus_start;
    put_byte({7'h21, 1'b0}, 1'b0, ack);
    put_byte(b0, 1'b0, ack);
    put_byte(b1, 1'b0, ack);
    put_byte(b2, 1'b0, ack);
    put_byte(b3, 1'b1, ack);
    check_eq("R10", "fourth byte ack", int'(ack), 1);
    bus_stop;
    wait_q(60);
    check_eq("R10", "rx_full after collision", int'(rx_full), 0);
    exp_q.push_back(b1); exp_q.push_back(b2); exp_q.push_back(b3);
    drain("R10");

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule